// File: doc/BRIEF.md
# Discrete I/O Channel with Sampled History

This block turns one timer channel into a general-purpose discrete pin. In input mode it records the recent life of the pin in a 16-bit history word. On each update the word moves one place toward bit 0 and takes the current synchronised pin level into its top bit, so the newest level sits in bit 15 and the oldest of the sixteen sits in bit 0. Software chooses what causes an update:
- a change of the pin level;
- an explicit host request;
- a free-running rate counter reaching a programmed period.

In output mode the channel drives the pin. The level changes only when the host issues a request strobe, which carries the wanted level. The raw pin input passes through a two-flop synchroniser before it is sampled or checked for edges. The asynchronous active-low reset is released through its own two-flop synchroniser.

Top module: `dio_channel`

## Requirements
- R1: After reset the history word reads 0x0000, `pin_oe` is 0 and `pin_out` is 0.
- R2: Every history update shifts the word one place toward bit 0, puts the synchronised pin level into bit 15 and drops the old bit 0.
- R3: With `upd_mode` = 2'b00 in input mode, each change of `pin_in` causes exactly one update. The update appears on the third rising clock edge after the change, and `host_req` has no effect on the history.
- R4: With `upd_mode` = 2'b01 in input mode, each clock cycle with `host_req` high causes one update, and changes on `pin_in` alone cause none.
- R5: With `upd_mode` = 2'b10 in input mode and a nonzero period P, an update happens on every P-th rising edge after the edge that wrote the period. A write to the period restarts this count.
- R6: A period value of 0 stops all rate-driven updates.
- R7: With `upd_mode` = 2'b11 the history word never changes.
- R8: With `mode_out` = 1, `pin_oe` is 1 from the next edge on. `pin_out` takes `host_level` on an edge where `host_req` is high, and holds its value on every other edge.
- R9: While `mode_out` = 1 the history word is frozen. While `mode_out` = 0, `host_req` never changes `pin_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Raw level of the pin, asynchronous |
| pin_out | output | 1 | Level driven onto the pin in output mode |
| pin_oe | output | 1 | Output driver enable |
| mode_out | input | 1 | 1 selects output mode, 0 selects input mode |
| upd_mode | input | 2 | History update trigger: 00 pin change, 01 host request, 10 rate, 11 none |
| host_req | input | 1 | Host request strobe, one cycle per request |
| host_level | input | 1 | Level applied to the pin by an output-mode request |
| period_wr | input | 1 | Write strobe for the rate period |
| period_wdata | input | 16 | New rate period, 0 disables |
| history | output | 16 | History word, newest sample in bit 15 |

## Verification
In pin-change mode the pin is stepped up and down while the history is sampled one edge before and at the expected edge. This separates a correct three-edge latency from an off-by-one, and the same phase shows that host strobes do nothing. Host mode is run with pin toggles and no requests, and then with sixteen back-to-back requests followed by one more. This shows that only requests count and that the old bit 0 really drops out. Rate mode is sampled just before and exactly at each P-th edge, and also after a rewrite in mid-count, which tells a restarted count from a free-running one. Output mode checks that level changes without a strobe are ignored and that input-mode strobes never reach the pin.

// File: rtl/dio_pkg.sv
package dio_pkg;
  typedef enum logic [1:0] {
    UPD_EDGE = 2'b00,
    UPD_HOST = 2'b01,
    UPD_RATE = 2'b10,
    UPD_NONE = 2'b11
  } upd_mode_e;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d    = chain_q << 1;
    chain_d[0] = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dio_rate_timer.sv
module dio_rate_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          period_wr,
  input  logic [CW-1:0] period_wdata,
  output logic          match
);
  logic [CW-1:0] period_q, period_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          period_zero;

  assign period_zero = (period_q == '0);

  always_comb begin
    period_d = period_wr ? period_wdata : period_q;
    match    = active && !period_zero && !period_wr &&
               (cnt_q == period_q - {{(CW-1){1'b0}}, 1'b1});
    if (period_wr || !active || period_zero || match) cnt_d = '0;
    else                                              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      cnt_q    <= '0;
    end else begin
      period_q <= period_d;
      cnt_q    <= cnt_d;
    end
  end

  AST_ZERO_PERIOD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    period_zero |-> !match) else $error("zero period fired"); // R6
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !period_zero |-> (cnt_q < period_q)) else $error("count past period"); // R5
  AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    period_wr |=> (cnt_q == '0)) else $error("write did not restart"); // R5
endmodule

// File: rtl/dio_history.sv
module dio_history #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          sample,
  output logic [HW-1:0] hist
);
  logic [HW-1:0] hist_q, hist_d;

  always_comb begin
    hist_d = hist_q;
    if (shift_en) hist_d = {sample, hist_q[HW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/dio_channel.sv
module dio_channel
  import dio_pkg::*;
#(
  parameter int HIST_W      = 16,
  parameter int PERIOD_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pin_in,
  output logic                pin_out,
  output logic                pin_oe,
  input  logic                mode_out,
  input  logic [1:0]          upd_mode,
  input  logic                host_req,
  input  logic                host_level,
  input  logic                period_wr,
  input  logic [PERIOD_W-1:0] period_wdata,
  output logic [HIST_W-1:0]   history
);
  localparam int MSB = HIST_W - 1;

  logic      rst_int_n;
  logic      pin_s;
  logic      pin_d_q;
  logic      pin_change;
  logic      rate_hit;
  logic      rate_active;
  logic      shift_en;
  logic      out_q, out_d;
  logic      oe_q, oe_d;
  upd_mode_e umode;

  dio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n));

  dio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .rst_n(rst_int_n), .d(pin_in), .q(pin_s));

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pin_d_q <= 1'b0;
    else            pin_d_q <= pin_s;
  end

  assign pin_change  = pin_s ^ pin_d_q;
  assign umode       = upd_mode_e'(upd_mode);
  assign rate_active = !mode_out && (umode == UPD_RATE);

  dio_rate_timer #(.CW(PERIOD_W)) u_rate (
    .clk(clk), .rst_n(rst_int_n), .active(rate_active),
    .period_wr(period_wr), .period_wdata(period_wdata), .match(rate_hit));

  always_comb begin
    shift_en = 1'b0;
    if (!mode_out) begin
      case (umode)
        UPD_EDGE: shift_en = pin_change;
        UPD_HOST: shift_en = host_req;
        UPD_RATE: shift_en = rate_hit;
        default:  shift_en = 1'b0;
      endcase
    end
  end

  dio_history #(.HW(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_int_n), .shift_en(shift_en),
    .sample(pin_s), .hist(history));

  always_comb begin
    oe_d  = mode_out;
    out_d = out_q;
    if (mode_out && host_req) out_d = host_level;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = oe_q;

  AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_int_n)
    shift_en |=> (history[MSB-1:0] == $past(history[MSB:1]))) else $error("shift order"); // R2
  AST_HOST_SAMPLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!mode_out && umode == UPD_HOST && host_req) |=> (history[MSB] == $past(pin_s)))
    else $error("host sample"); // R4
  AST_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (umode == UPD_NONE) |=> $stable(history)) else $error("none mode moved"); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(mode_out && host_req) |=> $stable(pin_out)) else $error("pin moved"); // R8
  AST_OUT_FREEZE: assert property (@(posedge clk) disable iff (!rst_int_n)
    mode_out |=> $stable(history)) else $error("history moved in output"); // R9
endmodule

// File: tb/dio_channel_tb.sv
`timescale 1ns/1ps
module dio_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pin_in;
  logic        pin_out;
  logic        pin_oe;
  logic        mode_out;
  logic [1:0]  upd_mode;
  logic        host_req;
  logic        host_level;
  logic        period_wr;
  logic [15:0] period_wdata;
  logic [15:0] history;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  dio_channel u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .mode_out(mode_out), .upd_mode(upd_mode),
    .host_req(host_req), .host_level(host_level), .period_wr(period_wr),
    .period_wdata(period_wdata), .history(history));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic pulse_req(input logic lvl);
    host_level = lvl;
    host_req   = 1'b1;
    tick(1);
    host_req   = 1'b0;
  endtask

  task automatic write_period(input logic [15:0] p);
    period_wdata = p;
    period_wr    = 1'b1;
    tick(1);
    period_wr    = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pin_in = 1'b0; mode_out = 1'b0; upd_mode = 2'b00;
    host_req = 1'b0; host_level = 1'b0; period_wr = 1'b0; period_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    chk("R1 history", history, 16'h0000);
    chk("R1 pin_oe", {15'd0, pin_oe}, 16'h0000);
    chk("R1 pin_out", {15'd0, pin_out}, 16'h0000);
  endtask

  task automatic t_edge_mode;
    upd_mode = 2'b00;
    pin_in = 1'b1;
    tick(2);
    chk("R3 before third edge", history, 16'h0000);
    tick(1);
    chk("R3 rise shifted", history, 16'h8000);
    pin_in = 1'b0;
    tick(3);
    chk("R3 fall shifted", history, 16'h4000);
    pulse_req(1'b1);
    tick(3);
    chk("R3 host req ignored", history, 16'h4000);
    pin_in = 1'b1;
    tick(3);
    chk("R2 R3 order", history, 16'hA000);
  endtask

  task automatic t_host_mode;
    upd_mode = 2'b01;
    pin_in = 1'b0;
    tick(4);
    pin_in = 1'b1;
    tick(4);
    pin_in = 1'b0;
    tick(4);
    chk("R4 pin change ignored", history, 16'hA000);
    pulse_req(1'b0);
    chk("R4 req samples low", history, 16'h5000);
    pin_in = 1'b1;
    tick(3);
    pulse_req(1'b0);
    chk("R4 req samples high", history, 16'hA800);
  endtask

  task automatic t_full_shift;
    upd_mode = 2'b01;
    host_req = 1'b1;
    tick(16);
    host_req = 1'b0;
    chk("R2 sixteen ones", history, 16'hFFFF);
    pin_in = 1'b0;
    tick(3);
    pulse_req(1'b0);
    chk("R2 bit0 dropped", history, 16'h7FFF);
  endtask

  task automatic t_none_mode;
    upd_mode = 2'b11;
    pin_in = 1'b1;
    tick(4);
    pulse_req(1'b0);
    tick(4);
    chk("R7 none mode frozen", history, 16'h7FFF);
  endtask

  task automatic t_rate_mode;
    upd_mode = 2'b10;
    write_period(16'd4);
    tick(3);
    chk("R5 before period", history, 16'h7FFF);
    tick(1);
    chk("R5 first rate update", history, 16'hBFFF);
    tick(4);
    chk("R5 second rate update", history, 16'hDFFF);
    tick(3);
    write_period(16'd4);
    tick(3);
    chk("R5 rewrite restarts", history, 16'hDFFF);
    tick(1);
    chk("R5 update after restart", history, 16'hEFFF);
  endtask

  task automatic t_rate_zero;
    upd_mode = 2'b10;
    write_period(16'd0);
    tick(40);
    chk("R6 zero period silent", history, 16'hEFFF);
  endtask

  task automatic t_output;
    mode_out = 1'b1;
    host_level = 1'b1;
    tick(1);
    chk("R8 oe asserted", {15'd0, pin_oe}, 16'h0001);
    chk("R8 level without req", {15'd0, pin_out}, 16'h0000);
    pulse_req(1'b1);
    chk("R8 req drives high", {15'd0, pin_out}, 16'h0001);
    host_level = 1'b0;
    tick(2);
    chk("R8 holds high", {15'd0, pin_out}, 16'h0001);
    pulse_req(1'b0);
    chk("R8 req drives low", {15'd0, pin_out}, 16'h0000);
    upd_mode = 2'b00;
    pin_in = 1'b0;
    tick(4);
    pin_in = 1'b1;
    tick(4);
    chk("R9 history frozen in output", history, 16'hEFFF);
    mode_out = 1'b0;
    pulse_req(1'b1);
    chk("R9 input req leaves pin", {15'd0, pin_out}, 16'h0000);
    chk("R9 oe released", {15'd0, pin_oe}, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_edge_mode();
    t_host_mode();
    t_full_shift();
    t_none_mode();
    t_rate_mode();
    t_rate_zero();
    t_output();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule